// File: doc/BRIEF.md
# DMA Burst Length Splitter

This block sits between a DMA engine and a memory-side bus master. It takes one transfer request (a word-aligned start address, a byte count and a direction) and turns it into a series of incrementing burst commands. Each command carries an address, a length in beats and a count of pad beats. Receive transfers become write bursts into memory and transmit transfers become read bursts. The data bus is 32 bits wide, so each beat moves four bytes, and a byte count that is not a multiple of four is rounded up to whole beats.

The burst length follows a programmed maximum between 1 and 16 beats. A burst is shorter than the maximum when fewer beats remain in the transfer. Close to a 4 KB address page edge, where a burst of the planned length would run into the next page, the block issues single-beat commands until the edge is passed. In packet buffer mode the trailing short burst of a transfer can be padded out to the full programmed length, with a separate enable for each direction. Pad beats are flagged on the beat outputs: on receive they write zeros, and on transmit the read data is dropped. Padding is skipped when the padded burst would leave the page.

Only one command is outstanding at a time. After a command is accepted, the block produces one beat flag per cycle. The next command is planned only after all beats have gone out and the completion strobe has arrived. If a direction enable is cleared, the burst already issued still runs to the end, and then the transfer stops.

Top module: `dma_burst_splitter`

## Requirements
- R1: The effective maximum burst length is taken from the 5-bit field `cfg_max_len`. A value of 0 acts as 1, values from 1 to 16 are used as given, and values above 16 act as 16. `cmd_len` always lies between 1 and the effective maximum.
- R2: When the remaining beats and the room left in the 4 KB page both reach the effective maximum, the command length equals the effective maximum and `cmd_pad` is 0.
- R3: The beat count of a request is `ceil(req_bytes/4)`. The last burst of a transfer is shortened to the number of beats still remaining. A request of 0 bytes produces no command.
- R4: The room in the page is `1024 - cmd_addr[11:2]` words. When the planned burst length (the smaller of the effective maximum and the remaining beats) is larger than that room, a single-beat command is issued instead. This repeats until the page edge is crossed, so no command ever spans two 4 KB pages.
- R5: When `cfg_pktbuf=1`, `cfg_pad_rx=1` and `req_is_tx=0`, a trailing short burst gets `cmd_len` equal to the effective maximum and `cmd_pad` equal to that maximum minus the data beats. `cmd_write` is 1 for such a burst.
- R6: When `cfg_pktbuf=1`, `cfg_pad_tx=1` and `req_is_tx=1`, the trailing short burst is extended in the same way. `cmd_write` is 0 for such a burst.
- R7: Padding is not applied when `cfg_pktbuf=0`, or when the pad enable for the request's direction is 0.
- R8: Padding is skipped, and the burst keeps its data length with `cmd_pad=0`, when the effective maximum exceeds the room left in the page.
- R9: At most one command is outstanding. `cmd_valid` does not rise again until all beats of the previous burst have been produced and `cmd_done` has been seen. After reset, `req_ready=1`, `cmd_valid=0` and `beat_valid=0`.
- R10: Clearing the enable of the active direction (`tx_en` for transmit, `rx_en` for receive) does not shorten a burst that has been accepted: all of its beats still appear. After that burst completes, no further command is issued and `req_ready` returns to 1.
- R11: After a command is accepted on `cmd_valid && cmd_ready`, exactly `cmd_len` cycles of `beat_valid` follow, starting two clock edges after the acceptance edge. `beat_pad` is 1 on the last `cmd_pad` of those beats and 0 on the others.
- R12: While `cmd_valid=1` and `cmd_ready=0`, `cmd_valid`, `cmd_addr`, `cmd_len` and `cmd_pad` stay unchanged.
- R13: The first command of a request is addressed at `req_addr`. Each following command starts at the previous address plus four times the previous burst's data (non-pad) beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_max_len | input | 5 | Programmed maximum burst length in beats |
| cfg_pktbuf | input | 1 | Packet buffer mode, which permits padding |
| cfg_pad_tx | input | 1 | Pad trailing transmit (read) bursts |
| cfg_pad_rx | input | 1 | Pad trailing receive (write) bursts |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_addr | input | 32 | Word-aligned start address |
| req_bytes | input | 16 | Transfer length in bytes |
| req_is_tx | input | 1 | 1 = transmit (memory read), 0 = receive (memory write) |
| cmd_valid | output | 1 | Burst command present |
| cmd_ready | input | 1 | Burst command taken |
| cmd_addr | output | 32 | Burst start address |
| cmd_len | output | 5 | Burst length in beats |
| cmd_pad | output | 5 | Number of trailing pad beats |
| cmd_write | output | 1 | 1 = write burst, 0 = read burst |
| cmd_done | input | 1 | Completion strobe for the outstanding burst |
| beat_valid | output | 1 | One beat of the current burst |
| beat_pad | output | 1 | Current beat is padding |

## Verification
The main function is tried with several request patterns. An aligned request that is a multiple of the maximum length shows whether the block issues full bursts and advances the address correctly. An odd byte count shows whether the block rounds up and shortens the tail. Zero and oversized length fields show whether the length is clamped. A request starting three words below a page edge shows whether the single-beat fallback gives way to normal bursts once the edge is passed. Padded tails are run in both directions, with packet mode off, and next to a page edge; together these show which of the conditions actually gates the padding. A transmit request whose enable drops during its first burst shows that the block stops after that burst without cutting it short.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PLAN = 2'd1,
    ST_CMD  = 2'd2,
    ST_XFER = 2'd3
  } dbs_state_e;
endpackage

// File: rtl/dbs_len_calc.sv
module dbs_len_calc #(
  parameter int ADDR_W    = 32,
  parameter int BEAT_W    = 15,
  parameter int LEN_W     = 5,
  parameter int CFG_W     = 5,
  parameter int MAX_BURST = 16,
  parameter int PAGE_W    = 12,
  parameter int OFF_W     = 2
) (
  input  logic [CFG_W-1:0]  cfg_len,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BEAT_W-1:0] rem,
  input  logic              pad_en,
  output logic [LEN_W-1:0]  len,
  output logic [LEN_W-1:0]  pad,
  output logic [LEN_W-1:0]  data
);
  localparam int ROOM_W     = PAGE_W - OFF_W + 1;
  localparam int PAGE_WORDS = 1 << (PAGE_W - OFF_W);

  logic [LEN_W-1:0]  max_len;
  logic [LEN_W-1:0]  short_n;
  logic [ROOM_W-1:0] room;

  always_comb begin
    if (cfg_len == '0)
      max_len = LEN_W'(1);
    else if (int'(cfg_len) > MAX_BURST)
      max_len = LEN_W'(MAX_BURST);
    else
      max_len = LEN_W'(cfg_len);

    room = ROOM_W'(PAGE_WORDS) - ROOM_W'(addr[PAGE_W-1:OFF_W]);

    if (rem < BEAT_W'(max_len))
      short_n = LEN_W'(rem);
    else
      short_n = max_len;

    if (ROOM_W'(short_n) > room) begin
      len  = LEN_W'(1);
      pad  = '0;
      data = LEN_W'(1);
    end else begin
      len  = short_n;
      pad  = '0;
      data = short_n;
      if (pad_en && (short_n < max_len) && (ROOM_W'(max_len) <= room)) begin
        len = max_len;
        pad = max_len - short_n;
      end
    end
  end
endmodule

// File: rtl/dbs_beat_seq.sv
module dbs_beat_seq #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] pad,
  output logic             beat_valid,
  output logic             beat_pad,
  output logic             idle
);
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] pad_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      pad_q      <= '0;
      beat_valid <= 1'b0;
      beat_pad   <= 1'b0;
    end else begin
      if (start) begin
        cnt   <= len;
        pad_q <= pad;
      end else if (cnt != '0) begin
        cnt <= cnt - LEN_W'(1);
      end
      beat_valid <= !start && (cnt != '0);
      beat_pad   <= !start && (cnt != '0) && (cnt <= pad_q);
    end
  end

  assign idle = (cnt == '0) && !beat_valid;

  // R11: once padding starts in a burst, every later beat of that burst is padding
  assert_pad_tail_R11: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_pad) |=> (!beat_valid || beat_pad));
endmodule

// File: rtl/dma_burst_splitter.sv
module dma_burst_splitter
  import dma_burst_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BYTES_W   = 16,
  parameter int DATA_W    = 32,
  parameter int CFG_W     = 5,
  parameter int MAX_BURST = 16,
  parameter int PAGE_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg_max_len,
  input  logic              cfg_pktbuf,
  input  logic              cfg_pad_tx,
  input  logic              cfg_pad_rx,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTES_W-1:0] req_bytes,
  input  logic              req_is_tx,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [$clog2(MAX_BURST+1)-1:0] cmd_len,
  output logic [$clog2(MAX_BURST+1)-1:0] cmd_pad,
  output logic              cmd_write,
  input  logic              cmd_done,
  output logic              beat_valid,
  output logic              beat_pad
);
  localparam int OFF_W  = $clog2(DATA_W / 8);
  localparam int BEAT_W = BYTES_W - OFF_W + 1;
  localparam int LEN_W  = $clog2(MAX_BURST + 1);
  localparam int ROOM_W = PAGE_W - OFF_W + 1;

  dbs_state_e        state;
  logic [ADDR_W-1:0] cur_addr;
  logic [BEAT_W-1:0] rem;
  logic              dir_tx;
  logic              done_seen;
  logic [LEN_W-1:0]  data_q;
  logic [LEN_W-1:0]  nxt_len, nxt_pad, nxt_data;
  logic [BYTES_W:0]  bytes_rnd;
  logic [BEAT_W-1:0] rem_init;
  logic              dir_en, pad_on, seq_idle, seq_start, finish;

  assign bytes_rnd = {1'b0, req_bytes} + (BYTES_W+1)'((1 << OFF_W) - 1);
  assign rem_init  = BEAT_W'(bytes_rnd >> OFF_W);
  assign dir_en    = dir_tx ? tx_en : rx_en;
  assign pad_on    = cfg_pktbuf && (dir_tx ? cfg_pad_tx : cfg_pad_rx);
  assign req_ready = (state == ST_IDLE);
  assign seq_start = (state == ST_CMD) && cmd_valid && cmd_ready;
  assign finish    = (state == ST_XFER) && seq_idle && (done_seen || cmd_done);

  dbs_len_calc #(
    .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .LEN_W(LEN_W), .CFG_W(CFG_W),
    .MAX_BURST(MAX_BURST), .PAGE_W(PAGE_W), .OFF_W(OFF_W)
  ) u_calc (
    .cfg_len(cfg_max_len), .addr(cur_addr), .rem(rem), .pad_en(pad_on),
    .len(nxt_len), .pad(nxt_pad), .data(nxt_data)
  );

  dbs_beat_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .start(seq_start), .len(cmd_len), .pad(cmd_pad),
    .beat_valid(beat_valid), .beat_pad(beat_pad), .idle(seq_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      rem       <= '0;
      dir_tx    <= 1'b0;
      done_seen <= 1'b0;
      data_q    <= '0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_len   <= '0;
      cmd_pad   <= '0;
      cmd_write <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_addr <= req_addr;
            rem      <= rem_init;
            dir_tx   <= req_is_tx;
            if (rem_init != '0) state <= ST_PLAN;
          end
        end
        ST_PLAN: begin
          if (!dir_en) begin
            state <= ST_IDLE;
          end else begin
            cmd_valid <= 1'b1;
            cmd_addr  <= cur_addr;
            cmd_len   <= nxt_len;
            cmd_pad   <= nxt_pad;
            cmd_write <= !dir_tx;
            data_q    <= nxt_data;
            state     <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (cmd_ready) begin
            cmd_valid <= 1'b0;
            done_seen <= 1'b0;
            state     <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (cmd_done) done_seen <= 1'b1;
          if (finish) begin
            cur_addr <= cur_addr + (ADDR_W'(data_q) << OFF_W);
            rem      <= rem - BEAT_W'(data_q);
            if ((rem == BEAT_W'(data_q)) || !dir_en) state <= ST_IDLE;
            else state <= ST_PLAN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_len_bounds_R1: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_len != '0) && (int'(cmd_len) <= MAX_BURST));

  assert_page_guard_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (ROOM_W'(cmd_addr[PAGE_W-1:OFF_W]) + ROOM_W'(cmd_len)
                   <= ROOM_W'(1 << (PAGE_W - OFF_W))));

  assert_pad_below_len_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_pad < cmd_len));

  assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> !cmd_valid);

  assert_cmd_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)
                                   && $stable(cmd_len) && $stable(cmd_pad)));
endmodule

// File: tb/dma_burst_splitter_tb.sv
module dma_burst_splitter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  cfg_max_len = 5'd8;
  logic        cfg_pktbuf = 1'b0, cfg_pad_tx = 1'b0, cfg_pad_rx = 1'b0;
  logic        tx_en = 1'b1, rx_en = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [15:0] req_bytes = '0;
  logic        req_is_tx = 1'b0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [31:0] cmd_addr;
  logic [4:0]  cmd_len, cmd_pad;
  logic        cmd_write;
  logic        cmd_done = 1'b0;
  logic        beat_valid, beat_pad;

  typedef struct packed {
    logic [31:0] addr;
    logic [4:0]  len;
    logic [4:0]  pad;
    logic        wr;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   cycles = 0;
  int   ncmd   = 0;
  bit   resp_busy = 1'b0;
  string cur_req = "R2";

  always #4 clk = ~clk;

  dma_burst_splitter u_dut (
    .clk(clk), .rst(rst), .cfg_max_len(cfg_max_len), .cfg_pktbuf(cfg_pktbuf),
    .cfg_pad_tx(cfg_pad_tx), .cfg_pad_rx(cfg_pad_rx), .tx_en(tx_en), .rx_en(rx_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_bytes(req_bytes), .req_is_tx(req_is_tx), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_pad(cmd_pad),
    .cmd_write(cmd_write), .cmd_done(cmd_done), .beat_valid(beat_valid),
    .beat_pad(beat_pad)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Expected command list built from the requirements
  task automatic push_expected(input logic [31:0] a0, input int bytes, input bit tx,
                               input int max_cmds);
    int lmax, rem, room, n, d, pushed;
    logic [31:0] a;
    bit pad_on;
    exp_t e;
    lmax = (cfg_max_len == 0) ? 1 : ((cfg_max_len > 16) ? 16 : int'(cfg_max_len));
    rem = (bytes + 3) / 4;
    a = a0;
    pushed = 0;
    pad_on = cfg_pktbuf && (tx ? cfg_pad_tx : cfg_pad_rx);
    while (rem > 0 && pushed < max_cmds) begin
      room = 1024 - int'(a[11:2]);
      n = (rem < lmax) ? rem : lmax;
      e.addr = a; e.wr = !tx; e.pad = '0;
      if (n > room) begin
        d = 1; e.len = 5'd1;
      end else begin
        d = n; e.len = 5'(n);
        if (pad_on && n < lmax && lmax <= room) begin
          e.len = 5'(lmax); e.pad = 5'(lmax - n);
        end
      end
      exp_q.push_back(e);
      pushed++;
      a = a + 32'(4 * d);
      rem = rem - d;
    end
  endtask

  task automatic send_req(input string tag, input logic [31:0] a, input int bytes,
                          input bit tx, input int max_cmds, input bit drop_en);
    int t;
    cur_req = tag;
    push_expected(a, bytes, tx, max_cmds);
    t = 0;
    while (!req_ready && t < 2000) begin @(negedge clk); t++; end
    req_addr = a; req_bytes = 16'(bytes); req_is_tx = tx; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (drop_en) begin
      t = 0;
      while (!beat_valid && t < 200) begin @(negedge clk); t++; end
      if (tx) tx_en = 1'b0; else rx_en = 1'b0;
    end
    t = 0;
    while (!(exp_q.size() == 0 && !resp_busy && req_ready) && t < 3000) begin
      @(negedge clk); t++;
    end
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, tag, "commands left unissued", exp_q.size(), 0);
    check(req_ready == 1'b1 && cmd_valid == 1'b0, tag, "idle after request",
          {req_ready, cmd_valid}, 2'b10);
    tx_en = 1'b1; rx_en = 1'b1;
  endtask

  // Responder and monitor: accepts commands, compares them, counts beats, completes
  initial begin : responder
    exp_t e;
    int stall, seen, idx;
    logic [31:0] a_hold;
    logic [4:0]  l_hold;
    forever begin
      @(negedge clk);
      if (!rst && cmd_valid) begin
        resp_busy = 1'b1;
        a_hold = cmd_addr; l_hold = cmd_len;
        stall = ncmd % 3;
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          check(cmd_valid && cmd_addr == a_hold && cmd_len == l_hold, "R12",
                "command held while stalled", {cmd_valid, cmd_addr, cmd_len},
                {1'b1, a_hold, l_hold});
        end
        cmd_ready = 1'b1;
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected command", cmd_addr, 0);
          e = '{addr: cmd_addr, len: cmd_len, pad: cmd_pad, wr: cmd_write};
        end else begin
          e = exp_q.pop_front();
          check(cmd_addr == e.addr, "R13", {cur_req, " command address"}, cmd_addr, e.addr);
          check(cmd_len == e.len, cur_req, "command length", cmd_len, e.len);
          check(cmd_pad == e.pad, cur_req, "pad beats", cmd_pad, e.pad);
          check(cmd_write == e.wr, cur_req, "direction", cmd_write, e.wr);
        end
        ncmd++;
        seen = 0; idx = 0;
        for (int c = 0; c < 40 && seen < int'(e.len); c++) begin
          @(negedge clk);
          cmd_ready = 1'b0;
          if (cmd_valid) check(1'b0, "R9", "command during beats", 1, 0);
          if (beat_valid) begin
            check(beat_pad == (idx >= int'(e.len) - int'(e.pad)), "R11",
                  "beat pad flag", beat_pad, (idx >= int'(e.len) - int'(e.pad)));
            idx++; seen++;
          end
        end
        @(negedge clk);
        check(seen == int'(e.len) && !beat_valid, "R11", "beat count", seen, e.len);
        for (int w = 0; w < (ncmd % 2) + 1; w++) begin
          if (cmd_valid) check(1'b0, "R9", "command before completion", 1, 0);
          @(negedge clk);
        end
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
        resp_busy = 1'b0;
      end
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        check(1'b0, "R9", "watchdog expired", cycles, 150000);
        finish_run();
      end
    end
  end

  initial begin : stimulus
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !cmd_valid && !beat_valid, "R9", "reset state",
          {req_ready, cmd_valid, beat_valid}, 3'b100);

    // R2 and R13: two full receive bursts
    cfg_max_len = 5'd8;
    send_req("R2", 32'h0000_1000, 64, 1'b0, 99, 1'b0);
    // R3: 45 bytes round up to 12 beats, tail of 4
    send_req("R3", 32'h0000_2040, 45, 1'b1, 99, 1'b0);
    // R3: zero bytes issue nothing
    send_req("R3", 32'h0000_3000, 0, 1'b0, 99, 1'b0);
    // R1: field 0 acts as single beats, field 20 clamps to 16
    cfg_max_len = 5'd0;
    send_req("R1", 32'h0000_4000, 8, 1'b0, 99, 1'b0);
    cfg_max_len = 5'd20;
    send_req("R1", 32'h0000_5000, 80, 1'b1, 99, 1'b0);
    // R4: three words below a page edge, singles then normal bursts
    cfg_max_len = 5'd8;
    send_req("R4", 32'h0000_0FF4, 64, 1'b0, 99, 1'b0);
    // R5: receive tail padded
    cfg_pktbuf = 1'b1; cfg_pad_rx = 1'b1; cfg_pad_tx = 1'b0;
    send_req("R5", 32'h0000_6000, 40, 1'b0, 99, 1'b0);
    // R7: transmit tail with only the receive pad bit set stays unpadded
    send_req("R7", 32'h0000_6100, 40, 1'b1, 99, 1'b0);
    // R6: transmit tail padded
    cfg_pad_tx = 1'b1;
    send_req("R6", 32'h0000_7000, 40, 1'b1, 99, 1'b0);
    // R8: pad would leave the page, so it is skipped
    send_req("R8", 32'h0000_1FF0, 12, 1'b0, 99, 1'b0);
    // R7: packet mode off disables padding in both directions
    cfg_pktbuf = 1'b0;
    send_req("R7", 32'h0000_8000, 40, 1'b0, 99, 1'b0);
    // R10: enable dropped during the first burst
    cfg_max_len = 5'd4;
    send_req("R10", 32'h0000_9000, 64, 1'b1, 1, 1'b1);
    // R10: the next request after re-enable still runs in full
    send_req("R10", 32'h0000_A000, 16, 1'b1, 99, 1'b0);

    finish_run();
  end
endmodule